// File: doc/BRIEF.md
# Six-Stage In-Order Pipeline Sequencer

This block is the control skeleton of an in-order instruction pipeline with six stages: fetch, decode, operand-address calculation, operand fetch, execute and write-back. Each stage holds at most one instruction. An instruction is carried only as an opaque tag. The block has no datapath, memory or ALU. It keeps the current fetch address, takes in one instruction word per cycle from a fetch source and moves every instruction forward one stage per cycle. It reports which stages hold valid work, and it gives a one-cycle retire pulse when an instruction leaves the write-back stage.

The control is uniform: every instruction passes through all six stages, even when it does not need some of them. Two inputs change the flow.

- **Hazard stall.** The hazard logic raises a stall input while an operand-address calculation waits for an older register write. The stall freezes the three front stages and sends a bubble into operand fetch. The older stages keep draining.
- **Branch resolve.** The execute stage reports each resolved conditional branch. A taken branch squashes the four younger stages and restarts fetch at the branch target. The branch itself goes on to write-back.

Top module: `pipe6_sequencer`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first cycle after it is released, every stage valid bit is 0, retire_o is 0 and fetch_addr_o is 0.
- R2: In a cycle with no stall and no taken resolve, fetch_rdy_o is 1. If fetch_vld_i is 1 in that cycle, fetch_tag_i enters the fetch stage and fetch_addr_o increments by 1. If fetch_vld_i is 0, the fetch stage becomes empty and fetch_addr_o holds.
- R3: Without stalls or flushes, every valid instruction moves one stage per clock with its tag unchanged. An instruction accepted at clock edge k is in write-back after edge k+5. So n instructions accepted back to back all retire within 6+(n-1) cycles; for example, 9 instructions take 14.
- R4: A taken resolve occurs when resolve_vld_i and resolve_taken_i are both 1 while the execute stage (index 4) is valid. On the next clock it empties the fetch, decode, address-calculation, operand-fetch and execute stages. On that same clock the branch moves into write-back, fetch_addr_o becomes resolve_target_i, and no fetch is accepted.
- R5: A resolve has no effect on the stages or on fetch_addr_o in two cases: when resolve_taken_i is 0, or when the execute stage is empty.
- R6: In a cycle with stall_i at 1 and no taken resolve:
  - fetch_rdy_o is 0 and fetch_addr_o holds.
  - The fetch, decode and address-calculation stages keep their valid bits and tags.
  - Operand fetch becomes empty.
  - Execute takes the old operand-fetch content, and write-back takes the old execute content.
- R7: When a taken resolve and a stall occur in the same cycle, the taken resolve wins.
- R8: retire_o is 1 for exactly one cycle for each valid instruction in write-back, and retire_tag_o then gives that instruction's tag.
- R9: Stage index i (0 = fetch, 1 = decode, 2 = address calculation, 3 = operand fetch, 4 = execute, 5 = write-back) reports its valid bit on stage_vld_o[i] and its tag on stage_tag_o[i*TAG_W +: TAG_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr_o | output | ADDR_W | Address of the next instruction to fetch |
| fetch_rdy_o | output | 1 | Fetch stage accepts an instruction this cycle |
| fetch_vld_i | input | 1 | An instruction word is present for fetch_addr_o |
| fetch_tag_i | input | TAG_W | Tag of the presented instruction |
| stall_i | input | 1 | Register hazard pending at address calculation |
| resolve_vld_i | input | 1 | Execute stage reports a resolved branch |
| resolve_taken_i | input | 1 | The resolved branch is taken |
| resolve_target_i | input | ADDR_W | Target address of the taken branch |
| stage_vld_o | output | 6 | Valid bit for each stage |
| stage_tag_o | output | 6*TAG_W | Tag for each stage, packed by stage index |
| retire_o | output | 1 | An instruction leaves write-back |
| retire_tag_o | output | TAG_W | Tag of the retiring instruction |

## Verification
The hardest situation to reach is a taken resolve in the same cycle as a stall, while the execute stage holds a real instruction and there is still a bubble from an earlier stall in flight further down. This is the only case where the priority between flush and hold shows at the ports.

The stimulus table gets there step by step:
1. It leaves a fetch gap to open a bubble.
2. It stalls once, so that a bubble is inserted mid-stream.
3. It sends a taken resolve while execute is empty, and a not-taken resolve while execute is full, to confirm that neither has any effect.
4. It raises stall and a taken resolve together, exactly when a known tag sits in execute.

The table then watches the redirected stream drain to empty.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;

    // Stage count and stage indices; the ordering is the flow order.
    localparam int unsigned NSTAGE  = 6;
    localparam int unsigned ST_FI   = 0;   // fetch
    localparam int unsigned ST_DI   = 1;   // decode
    localparam int unsigned ST_CA   = 2;   // operand-address calculation
    localparam int unsigned ST_FO   = 3;   // operand fetch
    localparam int unsigned ST_EX   = 4;   // execute
    localparam int unsigned ST_WB   = 5;   // write-back
    localparam int unsigned NFRONT  = ST_FO;  // stages frozen by a stall

    // Per-cycle advance decision for the whole pipe.
    typedef enum logic [1:0] {
        ADV_RUN   = 2'd0,   // everything shifts, fetch may accept
        ADV_HOLD  = 2'd1,   // front frozen, bubble into operand fetch
        ADV_FLUSH = 2'd2    // younger-than-execute squashed, redirect
    } adv_e;

endpackage

// File: rtl/pipe6_ctrl.sv
module pipe6_ctrl
    import pipe6_pkg::*;
(
    input  logic stall_i,
    input  logic resolve_vld_i,
    input  logic resolve_taken_i,
    input  logic ex_vld_i,
    input  logic fetch_vld_i,
    output adv_e mode_o,
    output logic accept_o,
    output logic fetch_rdy_o
);

    logic taken_flush;

    always_comb begin
        // A resolve only counts when a real instruction sits in execute.
        taken_flush = resolve_vld_i && resolve_taken_i && ex_vld_i;

        // Flush outranks the hazard stall.
        if (taken_flush) begin
            mode_o = ADV_FLUSH;
        end else if (stall_i) begin
            mode_o = ADV_HOLD;
        end else begin
            mode_o = ADV_RUN;
        end

        fetch_rdy_o = (mode_o == ADV_RUN);
        accept_o    = fetch_rdy_o && fetch_vld_i;
    end

endmodule

// File: rtl/pipe6_pc.sv
module pipe6_pc
    import pipe6_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  adv_e              mode_i,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] pc_o
);

    localparam logic [ADDR_W-1:0] PC_RESET = '0;
    localparam logic [ADDR_W-1:0] PC_STEP  = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (mode_i)
            ADV_FLUSH: st_d.pc = target_i;
            ADV_HOLD:  st_d.pc = st_q.pc;
            default: begin
                if (accept_i) begin
                    st_d.pc = st_q.pc + PC_STEP;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc <= PC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

endmodule

// File: rtl/pipe6_stages.sv
module pipe6_stages
    import pipe6_pkg::*;
#(
    parameter int unsigned TAG_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  adv_e                     mode_i,
    input  logic                     accept_i,
    input  logic [TAG_W-1:0]         fetch_tag_i,
    output logic [NSTAGE-1:0]        vld_o,
    output logic [NSTAGE*TAG_W-1:0]  tag_o
);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } slot_t;

    typedef struct packed {
        slot_t [NSTAGE-1:0] s;
    } pipe_state_t;

    localparam slot_t SLOT_EMPTY = '{vld: 1'b0, tag: '0};

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // Oldest end always drains: write-back takes execute, execute
        // takes operand fetch. Retire is the content of write-back.
        st_d.s[ST_WB] = st_q.s[ST_EX];

        unique case (mode_i)
            ADV_FLUSH: begin
                // Everything younger than the resolving branch dies.
                for (int i = 0; i < int'(ST_WB); i++) begin
                    st_d.s[i] = SLOT_EMPTY;
                end
            end
            ADV_HOLD: begin
                // Front stages keep their contents; a bubble enters
                // operand fetch while execute keeps draining.
                for (int i = 0; i < int'(NFRONT); i++) begin
                    st_d.s[i] = st_q.s[i];
                end
                st_d.s[ST_FO] = SLOT_EMPTY;
                st_d.s[ST_EX] = st_q.s[ST_FO];
            end
            default: begin
                for (int i = 1; i < int'(ST_WB); i++) begin
                    st_d.s[i] = st_q.s[i-1];
                end
                st_d.s[ST_FI].vld = accept_i;
                st_d.s[ST_FI].tag = accept_i ? fetch_tag_i : '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NSTAGE); i++) begin
                st_q.s[i] <= SLOT_EMPTY;
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < int'(NSTAGE); g++) begin : g_out
        assign vld_o[g]               = st_q.s[g].vld;
        assign tag_o[g*TAG_W +: TAG_W] = st_q.s[g].tag;
    end

endmodule

// File: rtl/pipe6_sequencer.sv
module pipe6_sequencer
    import pipe6_pkg::*;
#(
    parameter int unsigned TAG_W  = 8,
    parameter int unsigned ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [ADDR_W-1:0]        fetch_addr_o,
    output logic                     fetch_rdy_o,
    input  logic                     fetch_vld_i,
    input  logic [TAG_W-1:0]         fetch_tag_i,
    input  logic                     stall_i,
    input  logic                     resolve_vld_i,
    input  logic                     resolve_taken_i,
    input  logic [ADDR_W-1:0]        resolve_target_i,
    output logic [5:0]               stage_vld_o,
    output logic [6*TAG_W-1:0]       stage_tag_o,
    output logic                     retire_o,
    output logic [TAG_W-1:0]         retire_tag_o
);

    adv_e                    mode;
    logic                    accept;
    logic [NSTAGE-1:0]       vld;
    logic [NSTAGE*TAG_W-1:0] tag;

    pipe6_ctrl u_ctrl (
        .stall_i         (stall_i),
        .resolve_vld_i   (resolve_vld_i),
        .resolve_taken_i (resolve_taken_i),
        .ex_vld_i        (vld[ST_EX]),
        .fetch_vld_i     (fetch_vld_i),
        .mode_o          (mode),
        .accept_o        (accept),
        .fetch_rdy_o     (fetch_rdy_o)
    );

    pipe6_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .accept_i (accept),
        .target_i (resolve_target_i),
        .pc_o     (fetch_addr_o)
    );

    pipe6_stages #(.TAG_W(TAG_W)) u_stages (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .accept_i    (accept),
        .fetch_tag_i (fetch_tag_i),
        .vld_o       (vld),
        .tag_o       (tag)
    );

    assign stage_vld_o  = vld;
    assign stage_tag_o  = tag;
    assign retire_o     = vld[ST_WB];
    assign retire_tag_o = tag[ST_WB*TAG_W +: TAG_W];

endmodule

// File: rtl/pipe6_sequencer_chk.sv
module pipe6_sequencer_chk #(
    parameter int unsigned TAG_W  = 8,
    parameter int unsigned ADDR_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   fetch_addr_o,
    input logic                fetch_rdy_o,
    input logic                fetch_vld_i,
    input logic [TAG_W-1:0]    fetch_tag_i,
    input logic                stall_i,
    input logic                resolve_vld_i,
    input logic                resolve_taken_i,
    input logic [ADDR_W-1:0]   resolve_target_i,
    input logic [5:0]          stage_vld_o,
    input logic [6*TAG_W-1:0]  stage_tag_o,
    input logic                retire_o,
    input logic [TAG_W-1:0]    retire_tag_o
);

    logic flush_ev;
    assign flush_ev = resolve_vld_i && resolve_taken_i && stage_vld_o[4];

    // R4 / R7: taken resolve empties the younger stages and redirects.
    a_r4_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ev |=> (stage_vld_o[4:0] == 5'b0));

    a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ev |=> (fetch_addr_o == $past(resolve_target_i)));

    // R6: stall freezes the front and bubbles operand fetch.
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !flush_ev) |=> ($stable(stage_vld_o[2:0]) &&
                                    $stable(stage_tag_o[3*TAG_W-1:0]) &&
                                    !stage_vld_o[3] && $stable(fetch_addr_o)));

    // R2: accepted fetch steps the address and fills the fetch stage.
    a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_rdy_o && fetch_vld_i) |=> (stage_vld_o[0] &&
            stage_tag_o[TAG_W-1:0] == $past(fetch_tag_i) &&
            fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1)));

    // R8: execute content always becomes the next retirement.
    a_r8_retire_follows: assert property (@(posedge clk) disable iff (!rst_n)
        stage_vld_o[4] |=> (retire_o &&
            retire_tag_o == $past(stage_tag_o[4*TAG_W +: TAG_W])));

    // R3: write-back is always fed from execute.
    a_r3_drain: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage_vld_o[5] == $past(stage_vld_o[4])));

endmodule

bind pipe6_sequencer pipe6_sequencer_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .fetch_addr_o     (fetch_addr_o),
    .fetch_rdy_o      (fetch_rdy_o),
    .fetch_vld_i      (fetch_vld_i),
    .fetch_tag_i      (fetch_tag_i),
    .stall_i          (stall_i),
    .resolve_vld_i    (resolve_vld_i),
    .resolve_taken_i  (resolve_taken_i),
    .resolve_target_i (resolve_target_i),
    .stage_vld_o      (stage_vld_o),
    .stage_tag_o      (stage_tag_o),
    .retire_o         (retire_o),
    .retire_tag_o     (retire_tag_o)
);

// File: tb/pipe6_sequencer_bench.sv
module pipe6_sequencer_bench;

    localparam int TAG_W  = 8;
    localparam int ADDR_W = 16;
    localparam int NVEC   = 19;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   fetch_addr_o;
    logic                fetch_rdy_o;
    logic                fetch_vld_i = 1'b0;
    logic [TAG_W-1:0]    fetch_tag_i = '0;
    logic                stall_i = 1'b0;
    logic                resolve_vld_i = 1'b0;
    logic                resolve_taken_i = 1'b0;
    logic [ADDR_W-1:0]   resolve_target_i = '0;
    logic [5:0]          stage_vld_o;
    logic [6*TAG_W-1:0]  stage_tag_o;
    logic                retire_o;
    logic [TAG_W-1:0]    retire_tag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pipe6_sequencer #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_pipe6_sequencer (
        .clk(clk), .rst_n(rst_n),
        .fetch_addr_o(fetch_addr_o), .fetch_rdy_o(fetch_rdy_o),
        .fetch_vld_i(fetch_vld_i), .fetch_tag_i(fetch_tag_i),
        .stall_i(stall_i), .resolve_vld_i(resolve_vld_i),
        .resolve_taken_i(resolve_taken_i), .resolve_target_i(resolve_target_i),
        .stage_vld_o(stage_vld_o), .stage_tag_o(stage_tag_o),
        .retire_o(retire_o), .retire_tag_o(retire_tag_o)
    );

    typedef struct packed {
        logic        fv;
        logic [7:0]  tag;
        logic        st;
        logic        rv;
        logic        rt;
        logic [15:0] tgt;
        logic [5:0]  mask;
        logic [15:0] addr;
        logic        ret;
        logic [7:0]  rtag;
    } vec_t;

    // Stimulus for one clock edge and the expected ports after it.
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b000001, 16'h0001, 1'b0, 8'h00},
        '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b000011, 16'h0002, 1'b0, 8'h00},
        '{1'b1, 8'h12, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b000111, 16'h0003, 1'b0, 8'h00},
        '{1'b0, 8'h13, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b001110, 16'h0003, 1'b0, 8'h00},
        '{1'b1, 8'h14, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b011101, 16'h0004, 1'b0, 8'h00},
        '{1'b1, 8'h15, 1'b1, 1'b0, 1'b0, 16'h0000, 6'b110101, 16'h0004, 1'b1, 8'h10},
        '{1'b1, 8'h16, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b101011, 16'h0005, 1'b1, 8'h11},
        '{1'b1, 8'h17, 1'b0, 1'b1, 1'b1, 16'h0080, 6'b010111, 16'h0006, 1'b0, 8'h00},
        '{1'b1, 8'h18, 1'b0, 1'b1, 1'b0, 16'h0080, 6'b101111, 16'h0007, 1'b1, 8'h12},
        '{1'b1, 8'h19, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b011111, 16'h0008, 1'b0, 8'h00},
        '{1'b1, 8'h1A, 1'b1, 1'b1, 1'b1, 16'h0040, 6'b100000, 16'h0040, 1'b1, 8'h14},
        '{1'b1, 8'h1B, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b000001, 16'h0041, 1'b0, 8'h00},
        '{1'b1, 8'h1C, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b000011, 16'h0042, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b000110, 16'h0042, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b001100, 16'h0042, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b011000, 16'h0042, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b110000, 16'h0042, 1'b1, 8'h1B},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b100000, 16'h0042, 1'b1, 8'h1C},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 6'b000000, 16'h0042, 1'b0, 8'h00}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic fv, input logic [7:0] tg, input logic st,
                         input logic rv, input logic rt, input logic [15:0] tgt);
        fetch_vld_i      = fv;
        fetch_tag_i      = tg;
        stall_i          = st;
        resolve_vld_i    = rv;
        resolve_taken_i  = rt;
        resolve_target_i = tgt;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int last_k;
        int nret;
        logic [6*TAG_W-1:0] held;

        // R1: reset state, during reset and just after release.
        repeat (2) @(negedge clk);
        check("R1 vld in reset", 64'(stage_vld_o), 64'h0);
        check("R1 retire in reset", 64'(retire_o), 64'h0);
        check("R1 addr in reset", 64'(fetch_addr_o), 64'h0);
        rst_n = 1'b1;
        step();
        check("R1 vld after release", 64'(stage_vld_o), 64'h0);
        check("R1 addr after release", 64'(fetch_addr_o), 64'h0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i].fv, VEC[i].tag, VEC[i].st, VEC[i].rv, VEC[i].rt, VEC[i].tgt);
            step();
            check($sformatf("R4/R5/R6/R7 mask row %0d", i), 64'(stage_vld_o), 64'(VEC[i].mask));
            check($sformatf("R2/R4 addr row %0d", i), 64'(fetch_addr_o), 64'(VEC[i].addr));
            check($sformatf("R8 retire row %0d", i), 64'(retire_o), 64'(VEC[i].ret));
            if (VEC[i].ret) begin
                check($sformatf("R8 retire tag row %0d", i), 64'(retire_tag_o), 64'(VEC[i].rtag));
            end
        end

        // R1: reset in the middle of traffic.
        @(negedge clk);
        drive(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 16'h0000);
        step();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run vld", 64'(stage_vld_o), 64'h0);
        check("R1 mid-run addr", 64'(fetch_addr_o), 64'h0);
        @(negedge clk);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000);
        rst_n = 1'b1;

        // R9: tag packing by stage index.
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            drive(1'b1, 8'hA0 + 8'(k), 1'b0, 1'b0, 1'b0, 16'h0000);
            step();
        end
        check("R9 full mask", 64'(stage_vld_o), 64'h3F);
        check("R9 tag packing", 64'(stage_tag_o), 64'hA0A1A2A3A4A5);

        // R3: 9 back-to-back instructions finish at edge 14.
        do_reset();
        last_k = 0;
        nret   = 0;
        for (int k = 1; k <= 20; k++) begin
            drive(k <= 9, 8'(k), 1'b0, 1'b0, 1'b0, 16'h0000);
            step();
            if (retire_o) begin
                nret++;
                if (retire_tag_o == 8'd9) last_k = k;
            end
            @(negedge clk);
        end
        check("R3 last retire edge", 64'(last_k), 64'd14);
        check("R8 retire count", 64'(nret), 64'd9);

        // R6: tags held and fetch not ready during a stall.
        do_reset();
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 8'h31 + 8'(k), 1'b0, 1'b0, 1'b0, 16'h0000);
            step();
            @(negedge clk);
        end
        held = stage_tag_o;
        drive(1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 16'h0000);
        #1;
        check("R6 fetch_rdy low", 64'(fetch_rdy_o), 64'h0);
        step();
        @(negedge clk);
        step();
        check("R6 front tags held", 64'(stage_tag_o[3*TAG_W-1:0]), 64'(held[3*TAG_W-1:0]));
        check("R6 front tag value", 64'(stage_tag_o[3*TAG_W-1:0]), 64'h313233);
        check("R6 addr held", 64'(fetch_addr_o), 64'h3);
        @(negedge clk);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000);
        #1;
        check("R2 fetch_rdy high", 64'(fetch_rdy_o), 64'h1);

        finish_run();
    end

endmodule